// File: doc/BRIEF.md
# Sequential Restoring Divider

This block divides one N-bit integer by another over several clock cycles. It uses one subtractor and a single shift register that holds both the partial remainder and the quotient being built. A caller presents the dividend, the divisor and a mode bit, then pulses the start input. After a fixed number of cycles the block pulses its completion output. The quotient and remainder are presented at that point and stay unchanged until the next division completes.

The working register is loaded with the dividend magnitude in its low half and zeros above it, and is shifted left once before the loop begins. Each loop step compares the upper half with the divisor. When the upper half is not smaller, the difference replaces it and a one enters at the bottom of the register. Otherwise the upper half is kept and a zero enters. The register then shifts left. After N steps the low half is the quotient. The upper half, taken one position lower than its stored place, is the remainder.

In signed mode the operands are converted to magnitudes first, and the results are corrected afterwards. The quotient is negated when the operand signs differ, and the remainder takes the sign of the dividend. A zero divisor is reported by a flag.

Top module: `seq_divider`

## Requirements
- R1: After reset `busy_o` and `done_o` are 0, `div_zero_o` is 0, and `quotient_o` and `remainder_o` are zero.
- R2: In unsigned mode (`signed_i` = 0) with a nonzero divisor, `quotient_o` is floor(dividend / divisor) and `remainder_o` is dividend mod divisor.
- R3: `done_o` is asserted on the (N+1)th rising edge after the edge that accepts `start_i`.
- R4: `done_o` stays high for exactly one cycle.
- R5: `start_i` is ignored while `busy_o` is high. The operands in flight, the result and the completion time are unaffected.
- R6: A zero divisor completes normally with `quotient_o` all ones, `remainder_o` equal to the raw dividend bits and `div_zero_o` = 1, in either mode. `div_zero_o` is 0 for every nonzero divisor.
- R7: In signed mode (`signed_i` = 1, two's complement operands), the quotient is the true quotient rounded toward zero and truncated to N bits.
- R8: In signed mode, the remainder equals dividend minus quotient times divisor. Its sign follows the dividend, and its magnitude is below the divisor magnitude.
- R9: In signed mode, the most negative dividend divided by -1 yields the most negative value as quotient and zero as remainder.
- R10: Unsigned divisors with the top bit set divide correctly, with no partial remainder taken as negative because of its top bit.
- R11: `quotient_o`, `remainder_o` and `div_zero_o` change only on the cycle that `done_o` is high.
- R12: `busy_o` is high from the cycle after an accepted start until `done_o` rises, and it falls in the same cycle that `done_o` rises. A new start is accepted whenever `busy_o` is low, including while `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a division with the present operands when idle |
| signed_i | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend_i | input | WIDTH | Dividend |
| divisor_i | input | WIDTH | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| div_zero_o | output | 1 | Last completed division had a zero divisor |
| quotient_o | output | WIDTH | Quotient of the last completed division |
| remainder_o | output | WIDTH | Remainder of the last completed division |

## Verification
The assertions assume that operands matter only on the edge that accepts `start_i`, and that a start pulse arriving while the block is busy is harmless. They do not constrain what the operand inputs do between starts. The bound on the partial remainder holds only for a nonzero captured divisor, so that assertion is gated on it. Zero divisors are left to the bench. The stimulus drives every input on the falling edge. It holds `start_i` for one cycle. It deliberately raises `start_i` mid-division with different operands in some runs, and it changes the operands without a start while idle, to show they have no effect.

// File: rtl/div_pkg.sv
package div_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_FIX  = 2'd2
    } div_state_e;

endpackage

// File: rtl/div_operand_prep.sv
module div_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    input  logic             signed_mode,
    output logic [WIDTH-1:0] dvd_mag,
    output logic [WIDTH-1:0] dsr_mag,
    output logic             quot_neg,
    output logic             rem_neg
);

    logic dvd_sign;
    logic dsr_sign;

    always_comb begin
        dvd_sign = signed_mode & dividend[WIDTH-1];
        dsr_sign = signed_mode & divisor[WIDTH-1];
        // Magnitudes: the most negative value maps to 2^(WIDTH-1) unsigned
        dvd_mag  = dvd_sign ? (~dividend + 1'b1) : dividend;
        dsr_mag  = dsr_sign ? (~divisor + 1'b1) : divisor;
        quot_neg = dvd_sign ^ dsr_sign;
        rem_neg  = dvd_sign;
    end

endmodule

// File: rtl/div_restore_step.sv
module div_restore_step #(
    parameter int WIDTH = 32
) (
    input  logic [2*WIDTH:0] ext_cur,
    input  logic [WIDTH-1:0] dsr,
    output logic [2*WIDTH:0] ext_next
);

    // Upper part = spill bit plus left half, WIDTH+1 bits wide
    logic [WIDTH:0]   part;
    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] kept;
    logic             fits;

    always_comb begin
        part = ext_cur[2*WIDTH:WIDTH];
        // WIDTH+1-bit compare: a set top bit of the left half is magnitude
        fits = (part >= {1'b0, dsr});
        // When fits holds, the true difference is below dsr and fits WIDTH bits
        diff = part[WIDTH-1:0] - dsr;
        // Restore step: keep the old upper half when the subtract would go negative
        kept = fits ? diff : part[WIDTH-1:0];
        ext_next = {kept, ext_cur[WIDTH-1:0], fits};
    end

endmodule

// File: rtl/div_result_fix.sv
module div_result_fix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] q_mag,
    input  logic [WIDTH-1:0] r_mag,
    input  logic             quot_neg,
    input  logic             rem_neg,
    input  logic             dsr_zero,
    input  logic [WIDTH-1:0] dvd_raw,
    output logic [WIDTH-1:0] quot,
    output logic [WIDTH-1:0] rem
);

    always_comb begin
        if (dsr_zero) begin
            quot = '1;
            rem  = dvd_raw;
        end else begin
            quot = quot_neg ? (~q_mag + 1'b1) : q_mag;
            rem  = rem_neg  ? (~r_mag + 1'b1) : r_mag;
        end
    end

endmodule

// File: rtl/seq_divider.sv
module seq_divider
    import div_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             signed_i,
    input  logic [WIDTH-1:0] dividend_i,
    input  logic [WIDTH-1:0] divisor_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             div_zero_o,
    output logic [WIDTH-1:0] quotient_o,
    output logic [WIDTH-1:0] remainder_o
);

    localparam int EXT_W = 2*WIDTH + 1;
    localparam int CNT_W = $clog2(WIDTH + 1);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    typedef struct packed {
        div_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [EXT_W-1:0] ext;
        logic [WIDTH-1:0] dsr;
        logic [WIDTH-1:0] dvd_raw;
        logic             q_neg;
        logic             r_neg;
        logic [WIDTH-1:0] quot;
        logic [WIDTH-1:0] rem;
        logic             dz;
        logic             done;
    } div_regs_t;

    div_regs_t st_d, st_q;

    logic [WIDTH-1:0] dvd_mag, dsr_mag;
    logic             prep_qneg, prep_rneg;
    logic [EXT_W-1:0] ext_step;
    logic [WIDTH-1:0] fix_q, fix_r;
    logic             dsr_zero;

    assign dsr_zero = (st_q.dsr == '0);

    div_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .dividend    (dividend_i),
        .divisor     (divisor_i),
        .signed_mode (signed_i),
        .dvd_mag     (dvd_mag),
        .dsr_mag     (dsr_mag),
        .quot_neg    (prep_qneg),
        .rem_neg     (prep_rneg)
    );

    div_restore_step #(.WIDTH(WIDTH)) u_step (
        .ext_cur  (st_q.ext),
        .dsr      (st_q.dsr),
        .ext_next (ext_step)
    );

    div_result_fix #(.WIDTH(WIDTH)) u_fix (
        .q_mag    (st_q.ext[WIDTH-1:0]),
        .r_mag    (st_q.ext[EXT_W-1:WIDTH+1]),   // upper half taken one place lower
        .quot_neg (st_q.q_neg),
        .rem_neg  (st_q.r_neg),
        .dsr_zero (dsr_zero),
        .dvd_raw  (st_q.dvd_raw),
        .quot     (fix_q),
        .rem      (fix_r)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            S_IDLE: begin
                if (start_i) begin
                    st_d.state   = S_RUN;
                    st_d.cnt     = '0;
                    // dividend in the low half, already shifted left once
                    st_d.ext     = {{WIDTH{1'b0}}, dvd_mag, 1'b0};
                    st_d.dsr     = dsr_mag;
                    st_d.dvd_raw = dividend_i;
                    st_d.q_neg   = prep_qneg;
                    st_d.r_neg   = prep_rneg;
                end
            end
            S_RUN: begin
                st_d.ext = ext_step;
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST_STEP) begin
                    st_d.state = S_FIX;
                end
            end
            S_FIX: begin
                st_d.quot  = fix_q;
                st_d.rem   = fix_r;
                st_d.dz    = dsr_zero;
                st_d.done  = 1'b1;
                st_d.state = S_IDLE;
            end
            default: st_d.state = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = (st_q.state != S_IDLE);
    assign done_o      = st_q.done;
    assign div_zero_o  = st_q.dz;
    assign quotient_o  = st_q.quot;
    assign remainder_o = st_q.rem;

    // R2: the partial remainder stays below a nonzero divisor during the loop
    a_r2_partial_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.dsr != '0) |-> (st_q.ext[EXT_W-1:WIDTH+1] < st_q.dsr));

    // R4: single-cycle completion pulse
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5: a start seen while busy does not disturb the captured divisor
    a_r5_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(st_q.dsr));

    // R11: results move only with the completion pulse
    a_r11_hold_quot: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(quotient_o) && $stable(remainder_o) && $stable(div_zero_o)));

    // R12: busy falls exactly when done rises
    a_r12_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    a_r12_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

endmodule

// File: tb/seq_divider_bench.sv
module seq_divider_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [W-1:0] dividend_i = '0;
    logic [W-1:0] divisor_i = '0;
    logic         busy_o, done_o, div_zero_o;
    logic [W-1:0] quotient_o, remainder_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;   // 50 MHz

    seq_divider #(.WIDTH(W)) u_seq_divider (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .signed_i    (signed_i),
        .dividend_i  (dividend_i),
        .divisor_i   (divisor_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .div_zero_o  (div_zero_o),
        .quotient_o  (quotient_o),
        .remainder_o (remainder_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int to_int(input logic [W-1:0] v, input logic sgn);
        if (sgn && v[W-1]) return int'(v) - (1 << W);
        return int'(v);
    endfunction

    task automatic run_div(input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic s, input logic poke);
        int sa, sb, tq, tr, lat;
        logic [W-1:0] qe, re;
        logic ze;
        string tq_tag, tr_tag;
        sa = to_int(a, s);
        sb = to_int(b, s);
        if (sb == 0) begin
            qe = '1; re = a; ze = 1'b1;
            tq_tag = "R6 zero-divisor quotient"; tr_tag = "R6 zero-divisor remainder";
        end else begin
            tq = sa / sb;   // truncates toward zero
            tr = sa % sb;   // sign of dividend
            qe = tq[W-1:0]; re = tr[W-1:0]; ze = 1'b0;
            if (!s && b[W-1]) begin
                tq_tag = "R10 big-divisor quotient"; tr_tag = "R10 big-divisor remainder";
            end else if (!s) begin
                tq_tag = "R2 quotient"; tr_tag = "R2 remainder";
            end else if (a == {1'b1, {(W-1){1'b0}}} && b == '1) begin
                tq_tag = "R9 minval/-1 quotient"; tr_tag = "R9 minval/-1 remainder";
            end else begin
                tq_tag = "R7 signed quotient"; tr_tag = "R8 signed remainder";
            end
        end
        @(negedge clk);
        dividend_i = a; divisor_i = b; signed_i = s; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lat = 1;
        chk("R12 busy after start", 32'(busy_o), 32'(1));
        if (poke) begin
            dividend_i = ~a; divisor_i = b + 1'b1; signed_i = ~s; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            lat++;
        end
        while (!done_o && lat < 64) begin
            @(negedge clk);
            lat++;
        end
        // done on the (W+1)th edge after the accepting edge = (W+2)th falling edge
        chk(poke ? "R5 latency with ignored start" : "R3 latency", 32'(lat), 32'(W + 2));
        chk(tq_tag, 32'(quotient_o), 32'(qe));
        chk(tr_tag, 32'(remainder_o), 32'(re));
        chk("R6 zero flag", 32'(div_zero_o), 32'(ze));
        chk("R12 busy low at done", 32'(busy_o), 32'(0));
        @(negedge clk);
        chk("R4 done single cycle", 32'(done_o), 32'(0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [W-1:0] hq, hr;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 busy", 32'(busy_o), 32'(0));
        chk("R1 done", 32'(done_o), 32'(0));
        chk("R1 flag", 32'(div_zero_o), 32'(0));
        chk("R1 quotient", 32'(quotient_o), 32'(0));
        chk("R1 remainder", 32'(remainder_o), 32'(0));
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R6 / R10: exhaustive unsigned sweep
        for (int i = 0; i < (1 << W); i++)
            for (int j = 0; j < (1 << W); j++)
                run_div(W'(i), W'(j), 1'b0, 1'b0);

        // R7 / R8 / R9 / R6: exhaustive signed sweep
        for (int i = 0; i < (1 << W); i++)
            for (int j = 0; j < (1 << W); j++)
                run_div(W'(i), W'(j), 1'b1, 1'b0);

        // R5: start raised mid-division with other operands
        run_div(4'd13, 4'd3, 1'b0, 1'b1);
        run_div(4'd9, 4'd14, 1'b1, 1'b1);
        run_div(4'd7, 4'd0, 1'b0, 1'b1);

        // R11: outputs hold while idle and inputs wander without start
        run_div(4'd11, 4'd4, 1'b0, 1'b0);
        hq = quotient_o; hr = remainder_o;
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            dividend_i = W'(k * 3); divisor_i = W'(k); signed_i = k[0];
        end
        chk("R11 quotient held", 32'(quotient_o), 32'(hq));
        chk("R11 remainder held", 32'(remainder_o), 32'(hr));
        chk("R11 flag held", 32'(div_zero_o), 32'(0));
        chk("R11 idle no busy", 32'(busy_o), 32'(0));

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule